// File: doc/BRIEF.md
# Three-to-Two Instruction Word Packer

This block connects a 32-bit host bus to a 48-bit instruction store. Instructions move in pairs, and each pair fills exactly three host transfers. The host word always travels on the upper 32 lanes of the 48-bit data bus. The lower 16 lanes carry nothing in either direction.

On downloads, the packer keeps the bits left over from one write until the next write arrives. When an instruction is complete, it presents the full 48 bits for one cycle with a valid strobe. On uploads, the same three-step ordering runs in reverse. The packer pulls instructions from a source port and returns them as 32-bit read words.

A status field reports the position inside the three-step group, so the host can see when a group is still open. After an odd number of instructions, a group is left half full. A dummy flush access then discards the leftover bits. The block responds only when the packing-mode input selects this 32-bit instruction packing. In any other mode it holds its state.

Top module: `instr_packer32to48`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), `status` is 0, `instr_valid` is 0 and `rd_valid` is 0.
- R2: In write step 0 the host word `wr_data[47:16]` is held and no instruction is emitted. In step 1, one cycle after the write edge, `instr_valid` is 1 and `instr_out` is {step-0 word, step-1 word bits 31:16}.
- R3: In write step 2, one cycle after the write edge, `instr_valid` is 1 and `instr_out` is {step-1 word bits 15:0, step-2 word}.
- R4: `status` gives the step number in binary (0, 1, 2). Each accepted access advances it 0→1→2→0, and it never takes the value 3.
- R5: A flush (`flush` high in packing mode) at a non-zero step returns `status` to 0, emits nothing and discards the held bits. A flush at step 0 changes nothing.
- R6: Packing mode is `pack_mode` == 2'b11. In any other mode, reads, writes and flushes are ignored: `status` stays the same, no `instr_valid` or `rd_valid` is produced and `src_take` stays 0.
- R7: On reads, `src_take` is 1 in the same cycle as a read at steps 0 and 1, and 0 at step 2. One cycle later, `rd_valid` is 1 and `rd_data[47:16]` is: at step 0, instruction A bits 47:16; at step 1, {A bits 15:0, B bits 47:32}; at step 2, B bits 31:0.
- R8: `wr_data[15:0]` has no effect on `instr_out`, and `rd_data[15:0]` is always 0.
- R9: When `wr_en` and `rd_en` are both high, the write is performed and the read is ignored: `src_take` is 0 and `rd_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pack_mode | input | 2 | Packing-mode select; 2'b11 enables this packer |
| wr_en | input | 1 | Host write access |
| wr_data | input | 48 | Host data bus; host word on bits 47:16 |
| rd_en | input | 1 | Host read access |
| flush | input | 1 | Dummy access that drops a partial group |
| src_instr | input | 48 | Instruction to be uploaded |
| src_take | output | 1 | `src_instr` is consumed this cycle |
| rd_data | output | 48 | Upload word on bits 47:16, zero below |
| rd_valid | output | 1 | `rd_data` is valid |
| instr_out | output | 48 | Assembled instruction |
| instr_valid | output | 1 | One-cycle strobe for `instr_out` |
| status | output | 2 | Current step; non-zero while a group is open |

## Verification
The assertions assume that at most one of write, read or flush takes effect per cycle. The gating in the top module enforces this by giving flush priority over write, and write priority over read, so the assertions do not depend on the stimulus. They also assume that `pack_mode` is a settled level during each access, and the bench changes it only between accesses. The bench sweeps many instruction pairs with junk in the low lanes, and drives every non-packing mode mid-group. It also applies a flush at each of the three steps and issues simultaneous read and write accesses. All expected words are computed from the slicing rules.

// File: rtl/pk_pkg.sv
package pk_pkg;
   typedef enum logic [1:0] {
      PH_A = 2'd0,
      PH_B = 2'd1,
      PH_C = 2'd2
   } phase_t;

   function automatic phase_t next_phase(input phase_t p);
      case (p)
         PH_A:    return PH_B;
         PH_B:    return PH_C;
         default: return PH_A;
      endcase
   endfunction
endpackage

// File: rtl/pk_phase_ctr.sv
module pk_phase_ctr
   import pk_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   step,
   input  logic   clear,
   output phase_t phase
);
   always_ff @(posedge clk) begin
      if (rst)        phase <= PH_A;
      else if (clear) phase <= PH_A;
      else if (step)  phase <= next_phase(phase);
   end

   assert_phase_legal_R4: assert property (@(posedge clk) disable iff (rst)
      phase != phase_t'(2'd3));
   assert_phase_advance_R4: assert property (@(posedge clk) disable iff (rst)
      (step && !clear) |=> (phase == next_phase($past(phase))));
   assert_flush_home_R5: assert property (@(posedge clk) disable iff (rst)
      clear |=> (phase == PH_A));
endmodule

// File: rtl/pk_assemble.sv
module pk_assemble
   import pk_pkg::*;
#(
   parameter int INSTR_W = 48,
   parameter int HOST_W  = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               go,
   input  logic               clear,
   input  phase_t             phase,
   input  logic [HOST_W-1:0]  host,
   output logic [INSTR_W-1:0] instr,
   output logic               valid
);
   localparam int PART_W = INSTR_W - HOST_W;

   logic [HOST_W-1:0] hold;

   always_ff @(posedge clk) begin
      if (rst) begin
         hold  <= '0;
         instr <= '0;
         valid <= 1'b0;
      end else begin
         valid <= go && (phase != PH_A);
         if (clear) begin
            hold <= '0;
         end else if (go) begin
            case (phase)
               PH_A: hold <= host;
               PH_B: begin
                  instr <= {hold, host[HOST_W-1 -: PART_W]};
                  hold  <= {{PART_W{1'b0}}, host[PART_W-1:0]};
               end
               default: instr <= {hold[PART_W-1:0], host};
            endcase
         end
      end
   end

   assert_emit_after_step_R2: assert property (@(posedge clk) disable iff (rst)
      valid |-> ($past(go) && ($past(phase) != PH_A)));
endmodule

// File: rtl/pk_split.sv
module pk_split
   import pk_pkg::*;
#(
   parameter int INSTR_W = 48,
   parameter int HOST_W  = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               go,
   input  logic               clear,
   input  phase_t             phase,
   input  logic [INSTR_W-1:0] src,
   output logic               take,
   output logic [HOST_W-1:0]  word,
   output logic               valid
);
   localparam int PART_W = INSTR_W - HOST_W;

   logic [HOST_W-1:0] hold;

   assign take = go && (phase != PH_C);

   always_ff @(posedge clk) begin
      if (rst) begin
         hold  <= '0;
         word  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= go;
         if (clear) begin
            hold <= '0;
         end else if (go) begin
            case (phase)
               PH_A: begin
                  word <= src[INSTR_W-1 -: HOST_W];
                  hold <= {{PART_W{1'b0}}, src[PART_W-1:0]};
               end
               PH_B: begin
                  word <= {hold[PART_W-1:0], src[INSTR_W-1 -: PART_W]};
                  hold <= src[HOST_W-1:0];
               end
               default: word <= hold;
            endcase
         end
      end
   end

   assert_take_yields_word_R7: assert property (@(posedge clk) disable iff (rst)
      take |=> valid);
endmodule

// File: rtl/instr_packer32to48.sv
module instr_packer32to48
   import pk_pkg::*;
#(
   parameter int         INSTR_W   = 48,
   parameter int         HOST_W    = 32,
   parameter int         MODE_W    = 2,
   parameter logic [1:0] MODE_CODE = 2'b11
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [MODE_W-1:0]  pack_mode,
   input  logic               wr_en,
   input  logic [INSTR_W-1:0] wr_data,
   input  logic               rd_en,
   input  logic               flush,
   input  logic [INSTR_W-1:0] src_instr,
   output logic               src_take,
   output logic [INSTR_W-1:0] rd_data,
   output logic               rd_valid,
   output logic [INSTR_W-1:0] instr_out,
   output logic               instr_valid,
   output logic [1:0]         status
);
   localparam int PAD_W = INSTR_W - HOST_W;

   generate
      if (2 * INSTR_W != 3 * HOST_W) begin : g_bad_ratio
         $error("packer needs two instructions to fill exactly three host words");
      end
      if (MODE_W < 2) begin : g_bad_mode
         $error("mode input too narrow for the mode code");
      end
   endgenerate

   logic   active, wr_go, rd_go, clr;
   phase_t phase;
   logic [HOST_W-1:0] up_word;

   assign active = (pack_mode == MODE_W'(MODE_CODE));
   assign clr    = active && flush;
   assign wr_go  = active && wr_en && !flush;
   assign rd_go  = active && rd_en && !wr_en && !flush;
   assign status = phase;

   pk_phase_ctr u_phase (
      .clk   (clk),
      .rst   (rst),
      .step  (wr_go || rd_go),
      .clear (clr),
      .phase (phase)
   );

   pk_assemble #(.INSTR_W(INSTR_W), .HOST_W(HOST_W)) u_asm (
      .clk   (clk),
      .rst   (rst),
      .go    (wr_go),
      .clear (clr),
      .phase (phase),
      .host  (wr_data[INSTR_W-1 -: HOST_W]),
      .instr (instr_out),
      .valid (instr_valid)
   );

   pk_split #(.INSTR_W(INSTR_W), .HOST_W(HOST_W)) u_split (
      .clk   (clk),
      .rst   (rst),
      .go    (rd_go),
      .clear (clr),
      .phase (phase),
      .src   (src_instr),
      .take  (src_take),
      .word  (up_word),
      .valid (rd_valid)
   );

   generate
      if (PAD_W > 0) begin : g_pad
         assign rd_data = {up_word, {PAD_W{1'b0}}};
      end else begin : g_nopad
         assign rd_data = up_word;
      end
   endgenerate

   assert_mode_gate_R6: assert property (@(posedge clk) disable iff (rst)
      (pack_mode != MODE_W'(MODE_CODE)) |=> (!instr_valid && !rd_valid && $stable(status)));
   assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
      rd_valid |-> $past(rd_en && !wr_en));
   assert_no_take_on_write_R9: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> !src_take);
endmodule

// File: tb/sim_instr_packer32to48.sv
`timescale 1ns/1ps
module sim_instr_packer32to48;
   logic        clk = 1'b0;
   logic        rst;
   logic [1:0]  pack_mode;
   logic        wr_en, rd_en, flush;
   logic [47:0] wr_data, src_instr;
   logic        src_take, rd_valid, instr_valid;
   logic [47:0] rd_data, instr_out;
   logic [1:0]  status;

   int nchk = 0;
   int nerr = 0;
   logic tk;

   always #2.5 clk = ~clk;

   instr_packer32to48 u0 (
      .clk(clk), .rst(rst), .pack_mode(pack_mode), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .flush(flush), .src_instr(src_instr), .src_take(src_take),
      .rd_data(rd_data), .rd_valid(rd_valid), .instr_out(instr_out),
      .instr_valid(instr_valid), .status(status)
   );

   task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [47:0] mk(input int k);
      return (48'(k) * 48'h0000_9E37_79B9) ^ 48'h5A5A_C3C3_0F0F;
   endfunction

   task automatic acc(input logic w, input logic r, input logic f, input logic [1:0] m,
                      input logic [47:0] d, output logic take_s);
      @(negedge clk);
      wr_en = w; rd_en = r; flush = f; pack_mode = m; wr_data = d;
      #1 take_s = src_take;
      @(posedge clk);
      #1;
      wr_en = 1'b0; rd_en = 1'b0; flush = 1'b0; pack_mode = 2'b11;
   endtask

   task automatic write_pair(input logic [47:0] a, input logic [47:0] b, input int k);
      acc(1, 0, 0, 2'b11, {a[47:16], 16'(k * 7 + 3)}, tk);
      chk("R2 no emit at step 0", 48'(instr_valid), 48'd0);
      chk("R4 status after step 0", 48'(status), 48'd1);
      acc(1, 0, 0, 2'b11, {a[15:0], b[47:32], 16'(k * 13 + 5)}, tk);
      chk("R2 valid at step 1", 48'(instr_valid), 48'd1);
      chk("R2 R8 first instr", instr_out, a);
      chk("R4 status after step 1", 48'(status), 48'd2);
      acc(1, 0, 0, 2'b11, {b[31:0], 16'hFFFF}, tk);
      chk("R3 valid at step 2", 48'(instr_valid), 48'd1);
      chk("R3 R8 second instr", instr_out, b);
      chk("R4 status wraps", 48'(status), 48'd0);
   endtask

   initial begin : watchdog
      #(200000 * 5);
      nerr++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin : main
      logic [47:0] a, b;
      rst = 1'b1; pack_mode = 2'b11; wr_en = 0; rd_en = 0; flush = 0;
      wr_data = '0; src_instr = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 status reset", 48'(status), 48'd0);
      chk("R1 instr_valid reset", 48'(instr_valid), 48'd0);
      chk("R1 rd_valid reset", 48'(rd_valid), 48'd0);
      @(negedge clk) rst = 1'b0;

      for (int k = 0; k < 60; k++) write_pair(mk(2 * k), mk(2 * k + 1), k);
      write_pair(48'hFFFF_FFFF_FFFF, 48'h0, 1);
      write_pair(48'h0, 48'hFFFF_FFFF_FFFF, 2);

      // R5: flush at step 1, at step 2 and at step 0
      a = mk(500); b = mk(501);
      acc(1, 0, 0, 2'b11, {a[47:16], 16'h0}, tk);
      acc(0, 0, 1, 2'b11, '0, tk);
      chk("R5 flush step1 status", 48'(status), 48'd0);
      chk("R5 flush no emit", 48'(instr_valid), 48'd0);
      write_pair(a, b, 9);
      acc(1, 0, 0, 2'b11, {a[47:16], 16'h0}, tk);
      acc(1, 0, 0, 2'b11, {a[15:0], b[47:32], 16'h0}, tk);
      chk("R5 odd instr out", instr_out, a);
      acc(0, 0, 1, 2'b11, '0, tk);
      chk("R5 flush step2 status", 48'(status), 48'd0);
      chk("R5 flush step2 no emit", 48'(instr_valid), 48'd0);
      acc(0, 0, 1, 2'b11, '0, tk);
      chk("R5 flush step0 status", 48'(status), 48'd0);
      chk("R5 flush step0 no emit", 48'(instr_valid), 48'd0);
      write_pair(b, a, 4);

      // R6: other modes ignored mid-group
      for (int m = 0; m < 3; m++) begin
         a = mk(700 + m); b = mk(800 + m);
         acc(1, 0, 0, 2'b11, {a[47:16], 16'h0}, tk);
         acc(1, 0, 0, 2'(m), {48'hDEAD_BEEF_0000}, tk);
         chk("R6 write ignored status", 48'(status), 48'd1);
         chk("R6 write ignored valid", 48'(instr_valid), 48'd0);
         acc(0, 1, 0, 2'(m), '0, tk);
         chk("R6 read ignored take", 48'(tk), 48'd0);
         chk("R6 read ignored rd_valid", 48'(rd_valid), 48'd0);
         acc(0, 0, 1, 2'(m), '0, tk);
         chk("R6 flush ignored status", 48'(status), 48'd1);
         acc(1, 0, 0, 2'b11, {a[15:0], b[47:32], 16'h0}, tk);
         chk("R6 group intact", instr_out, a);
         acc(1, 0, 0, 2'b11, {b[31:0], 16'h0}, tk);
         chk("R6 group intact 2", instr_out, b);
      end

      // R7 R8: uploads
      for (int k = 0; k < 40; k++) begin
         a = mk(1000 + 2 * k); b = mk(1001 + 2 * k);
         src_instr = a;
         acc(0, 1, 0, 2'b11, '0, tk);
         chk("R7 take step0", 48'(tk), 48'd1);
         chk("R7 rd_valid", 48'(rd_valid), 48'd1);
         chk("R7 R8 read word 0", rd_data, {a[47:16], 16'h0});
         src_instr = b;
         acc(0, 1, 0, 2'b11, '0, tk);
         chk("R7 take step1", 48'(tk), 48'd1);
         chk("R7 R8 read word 1", rd_data, {a[15:0], b[47:32], 16'h0});
         src_instr = mk(9999);
         acc(0, 1, 0, 2'b11, '0, tk);
         chk("R7 no take step2", 48'(tk), 48'd0);
         chk("R7 R8 read word 2", rd_data, {b[31:0], 16'h0});
         chk("R4 read wraps", 48'(status), 48'd0);
      end

      // R9: simultaneous read and write
      a = mk(3000); b = mk(3001);
      src_instr = mk(42);
      acc(1, 1, 0, 2'b11, {a[47:16], 16'h0}, tk);
      chk("R9 no take", 48'(tk), 48'd0);
      chk("R9 no rd_valid", 48'(rd_valid), 48'd0);
      chk("R9 write done", 48'(status), 48'd1);
      acc(1, 1, 0, 2'b11, {a[15:0], b[47:32], 16'h0}, tk);
      chk("R9 write wins instr", instr_out, a);
      acc(1, 0, 0, 2'b11, {b[31:0], 16'h0}, tk);
      chk("R9 write wins instr 2", instr_out, b);

      // R1: reset mid-group
      acc(1, 0, 0, 2'b11, {a[47:16], 16'h0}, tk);
      @(negedge clk) rst = 1'b1;
      @(posedge clk); #1;
      chk("R1 reset mid-group status", 48'(status), 48'd0);
      @(negedge clk) rst = 1'b0;
      write_pair(b, a, 11);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule